// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache with Posted Write Buffer

This block sits between a processor port and a slower main-memory port. It keeps a parameterised number of 16-byte lines, each with a tag and a valid bit, and serves 32-bit word reads and writes on 32-bit byte addresses. A read that finds its line valid with a matching tag completes in the cycle it is presented. A read that misses fetches the whole line from memory one word at a time, marks the line valid, and then completes.

Every store goes to main memory through a small posted write buffer, so the processor waits only when that buffer is full. A store whose line is resident also updates the cached word. A store that misses does not allocate a line. Before a read miss fetches its line, it waits until the buffer holds no store to that line, so the fetched copy always carries the newest data. The word at the indexed line is always driven on the read data port, so a processor may use it speculatively and throw it away when the ready signal stays low.

Top module: `dmc_cache`

## Requirements
- R1: After reset every line is invalid, the memory port is idle (mem_req low), and the first read of any line is a miss.
- R2: Address bits [3:2] select the word in a line, the next log2(NUM_LINES) bits select the line and all higher bits form the tag; lines with different index bits coexist, and a line with the same index but a different tag replaces the resident one.
- R3: A read whose line is valid with a matching tag raises cpu_ready in the same cycle with the addressed word on cpu_rdata, and issues no memory read.
- R4: A read miss issues exactly four memory reads (mem_we low), at the line base plus 0, 4, 8 and 12 in that order, then marks the line valid and completes with the requested word.
- R5: Every accepted write produces exactly one memory write (mem_we high) with the same word address and data, and memory writes appear in the order the processor's writes were accepted.
- R6: A write hit updates the cached word so a later read hit returns it; a write miss leaves the line at that index untouched and allocates nothing.
- R7: A write is accepted (cpu_ready high) in the cycle it is presented while the buffer has a free entry; while the buffer is full, cpu_ready stays low until an entry drains.
- R8: A read miss issues no line-fetch read while the buffer still holds a write to the missing line, so the returned word reflects every earlier write.
- R9: A memory request keeps mem_req, mem_we, mem_addr and mem_wdata unchanged until the cycle mem_ack is high; only one request is outstanding.
- R10: cpu_rdata carries the word at the indexed line and word position in the request cycle even on a miss, while cpu_ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Indexed cached word (valid when cpu_ready on a read) |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the current request |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
The bench slows memory so that a store is still buffered when a read misses on the same line; a design that fetched before draining would return the stale memory word. It fills the buffer with five stores under long latency, where a design that ignored the full state would drop or overwrite a store and the memory-side write order would no longer match. It also stores to an address that aliases a resident line and then reads the resident line, which catches a design that allocated or corrupted on a write miss, and it checks the speculative word in the first cycle of a miss, which a design that blanked or late-muxed the data would get wrong.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  localparam int unsigned ADDR_W      = 32;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned OFFS_W      = 4;
  localparam int unsigned WSEL_W      = 2;
  localparam int unsigned LINE_ADDR_W = ADDR_W - OFFS_W;
  localparam int unsigned WADDR_W     = ADDR_W - 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_FILL  = 2'd2
  } ctl_state_t;
endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int unsigned LINES = 16,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [1:0]       lk_word,
  output logic [31:0]      lk_data,
  output logic [TAG_W-1:0] lk_tag,
  output logic             lk_valid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_word,
  input  logic [31:0]      wr_data,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag
);
  logic             valid_q [LINES];
  logic [TAG_W-1:0] tag_q   [LINES];
  logic [3:0][31:0] data_q  [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               valid_q[g] <= 1'b0;
      else if (set_en && set_idx == IDX_W'(g))  valid_q[g] <= 1'b1;
      else if (inv_en && inv_idx == IDX_W'(g))  valid_q[g] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (set_en && set_idx == IDX_W'(g)) tag_q[g] <= set_tag;
      if (wr_en && wr_idx == IDX_W'(g))   data_q[g][wr_word] <= wr_data;
    end
  end

  assign lk_valid = valid_q[lk_idx];
  assign lk_tag   = tag_q[lk_idx];
  assign lk_data  = data_q[lk_idx][lk_word];
endmodule

// File: rtl/dmc_post_buffer.sv
module dmc_post_buffer #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PTR_W = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  logic [29:0] push_waddr,
  input  logic [31:0] push_data,
  input  logic        pop,
  output logic [29:0] head_waddr,
  output logic [31:0] head_data,
  output logic        empty,
  output logic        full,
  input  logic [27:0] probe_line,
  input  logic        probe_skip_head,
  output logic        probe_hit
);
  logic [29:0]    waddr_q [DEPTH];
  logic [31:0]    data_q  [DEPTH];
  logic           occ_q   [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [PTR_W:0]   count_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty      = (count_q == '0);
  assign full       = (count_q == (PTR_W+1)'(DEPTH));
  assign head_waddr = waddr_q[rd_ptr_q];
  assign head_data  = data_q[rd_ptr_q];

  always_comb begin
    probe_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (occ_q[i] && waddr_q[i][29:2] == probe_line &&
          !(probe_skip_head && rd_ptr_q == PTR_W'(i)))
        probe_hit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      for (int i = 0; i < DEPTH; i++) occ_q[i] <= 1'b0;
    end else begin
      if (push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      for (int i = 0; i < DEPTH; i++) begin
        if (pop && rd_ptr_q == PTR_W'(i))       occ_q[i] <= 1'b0;
        else if (push && wr_ptr_q == PTR_W'(i)) occ_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      waddr_q[wr_ptr_q] <= push_waddr;
      data_q[wr_ptr_q]  <= push_data;
    end
  end
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned WB_DEPTH  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_ready,
  output logic [31:0] cpu_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  import dmc_pkg::*;

  localparam int unsigned INDEX_W  = $clog2(NUM_LINES);
  localparam int unsigned TAG_W    = LINE_ADDR_W - INDEX_W;
  localparam int unsigned WB_PTR_W = $clog2(WB_DEPTH);

  function automatic logic [INDEX_W-1:0] idx_of(input logic [LINE_ADDR_W-1:0] ln);
    return ln[INDEX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [LINE_ADDR_W-1:0] ln);
    return ln[LINE_ADDR_W-1:INDEX_W];
  endfunction

  ctl_state_t                state_q;
  logic [LINE_ADDR_W-1:0]    miss_line_q;
  logic [WSEL_W-1:0]         fill_word_q;

  logic [LINE_ADDR_W-1:0]    req_line;
  logic [WSEL_W-1:0]         req_word;
  logic                      unused_addr_bits;
  logic [31:0]               lk_data;
  logic [TAG_W-1:0]          lk_tag;
  logic                      lk_valid;

  // Named events, also observed by the checker.
  logic lookup_hit, in_idle, rd_hit_ev, rd_miss_ev, wr_hit_ev;
  logic wb_push, wb_pop, wb_empty, wb_full, probe_hit;
  logic fill_active, fill_beat, fill_done, fill_start;
  logic [29:0] head_waddr;
  logic [31:0] head_data;

  assign req_line         = cpu_addr[ADDR_W-1:OFFS_W];
  assign req_word         = cpu_addr[OFFS_W-1:2];
  assign unused_addr_bits = ^cpu_addr[1:0];

  assign in_idle    = (state_q == ST_IDLE);
  assign lookup_hit = lk_valid && (lk_tag == tag_of(req_line));
  assign rd_hit_ev  = in_idle && cpu_req && !cpu_we && lookup_hit;
  assign rd_miss_ev = in_idle && cpu_req && !cpu_we && !lookup_hit;
  assign wb_push    = in_idle && cpu_req && cpu_we && !wb_full;
  assign wr_hit_ev  = wb_push && lookup_hit;

  assign cpu_ready  = rd_hit_ev || wb_push;
  assign cpu_rdata  = lk_data;

  assign fill_active = (state_q == ST_FILL);
  assign fill_beat   = fill_active && mem_ack;
  assign fill_done   = fill_beat && (fill_word_q == 2'd3);
  assign wb_pop      = !fill_active && !wb_empty && mem_ack;
  assign fill_start  = (state_q == ST_DRAIN) && !probe_hit && (wb_empty || wb_pop);

  assign mem_req   = fill_active || !wb_empty;
  assign mem_we    = !fill_active;
  assign mem_addr  = fill_active ? {miss_line_q, fill_word_q, 2'b00} : {head_waddr, 2'b00};
  assign mem_wdata = head_data;

  dmc_line_store #(
    .LINES (NUM_LINES),
    .IDX_W (INDEX_W),
    .TAG_W (TAG_W)
  ) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (idx_of(req_line)),
    .lk_word  (req_word),
    .lk_data  (lk_data),
    .lk_tag   (lk_tag),
    .lk_valid (lk_valid),
    .wr_en    (wr_hit_ev || fill_beat),
    .wr_idx   (fill_active ? idx_of(miss_line_q) : idx_of(req_line)),
    .wr_word  (fill_active ? fill_word_q : req_word),
    .wr_data  (fill_active ? mem_rdata : cpu_wdata),
    .inv_en   (rd_miss_ev),
    .inv_idx  (idx_of(req_line)),
    .set_en   (fill_done),
    .set_idx  (idx_of(miss_line_q)),
    .set_tag  (tag_of(miss_line_q))
  );

  dmc_post_buffer #(
    .DEPTH (WB_DEPTH),
    .PTR_W (WB_PTR_W)
  ) i_wbuf (
    .clk             (clk),
    .rst_n           (rst_n),
    .push            (wb_push),
    .push_waddr      (cpu_addr[ADDR_W-1:2]),
    .push_data       (cpu_wdata),
    .pop             (wb_pop),
    .head_waddr      (head_waddr),
    .head_data       (head_data),
    .empty           (wb_empty),
    .full            (wb_full),
    .probe_line      (miss_line_q),
    .probe_skip_head (wb_pop),
    .probe_hit       (probe_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      miss_line_q <= '0;
      fill_word_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (rd_miss_ev) begin
          state_q     <= ST_DRAIN;
          miss_line_q <= req_line;
        end
        ST_DRAIN: if (fill_start) begin
          state_q     <= ST_FILL;
          fill_word_q <= '0;
        end
        ST_FILL: if (fill_beat) begin
          fill_word_q <= fill_word_q + 2'd1;
          if (fill_done) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_we,
  input logic        cpu_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        fill_active,
  input logic        fill_beat,
  input logic        fill_done,
  input logic        wb_push,
  input logic        wb_empty,
  input logic        wb_full,
  input logic        probe_hit
);
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !mem_req);

  assert_hit_without_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !cpu_we) |-> !fill_active);

  assert_fill_sequence_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_beat && !fill_done) |=> (fill_active && mem_req && !mem_we &&
                                   mem_addr == $past(mem_addr) + 32'd4));

  assert_fill_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !fill_active);

  assert_push_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_push |=> !wb_empty);

  assert_full_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && wb_full) |-> !cpu_ready);

  assert_fill_after_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_active |-> !probe_hit);

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) &&
                               $stable(mem_wdata)));
endmodule

bind dmc_cache dmc_checker i_dmc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_req     (cpu_req),
  .cpu_we      (cpu_we),
  .cpu_ready   (cpu_ready),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_ack     (mem_ack),
  .fill_active (fill_active),
  .fill_beat   (fill_beat),
  .fill_done   (fill_done),
  .wb_push     (wb_push),
  .wb_empty    (wb_empty),
  .wb_full     (wb_full),
  .probe_hit   (probe_hit)
);

// File: tb/test_dmc_cache.sv
module test_dmc_cache;
  localparam int CLK_PERIOD = 10;
  localparam int MODEL_WORDS = 1024;

  logic        clk, rst_n;
  logic        cpu_req, cpu_we, cpu_ready;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  dmc_cache #(.NUM_LINES(16), .WB_DEPTH(4)) i_dmc_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  logic [31:0] mem_model [MODEL_WORDS];
  logic [31:0] ref_mem   [MODEL_WORDS];
  int checks = 0;
  int errors = 0;
  int mem_lat = 2;

  logic [31:0] exp_rd_q[$];
  string       exp_rd_tag_q[$];
  logic [31:0] exp_wa_q[$];
  logic [31:0] exp_wd_q[$];
  logic [31:0] exp_fill_q[$];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [31:0] a, input logic [31:0] d,
                           input bit expect_wait, input string tag);
    int waits = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; waits++; end
    ref_mem[a[11:2]] = d;
    exp_wa_q.push_back({a[31:2], 2'b00});
    exp_wd_q.push_back(d);
    if (expect_wait) check(waits > 0, tag, waits, 32'd1);
    else             check(waits == 0, tag, waits, 32'd0);
    @(posedge clk); #1;
    cpu_req = 1'b0;
  endtask

  task automatic cpu_read(input logic [31:0] a, input bit expect_miss, input string tag,
                          output logic [31:0] first_data, output logic first_ready);
    int waits = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    if (expect_miss)
      for (int w = 0; w < 4; w++) exp_fill_q.push_back({a[31:4], w[1:0], 2'b00});
    exp_rd_q.push_back(ref_mem[a[11:2]]);
    exp_rd_tag_q.push_back(tag);
    #1;
    first_data  = cpu_rdata;
    first_ready = cpu_ready;
    while (!cpu_ready) begin @(negedge clk); #1; waits++; end
    if (expect_miss) check(waits > 0, tag, waits, 32'd1);
    else             check(waits == 0, tag, waits, 32'd0);
    @(posedge clk); #1;
    cpu_req = 1'b0;
  endtask

  // Read-data monitor: pops the scoreboard on each completed read.
  always @(negedge clk) begin
    #2;
    if (rst_n && cpu_req && !cpu_we && cpu_ready) begin
      if (exp_rd_q.size() == 0) check(1'b0, "R3 unexpected read", cpu_rdata, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_rd_q.pop_front();
        t = exp_rd_tag_q.pop_front();
        check(cpu_rdata == e, t, cpu_rdata, e);
      end
    end
  end

  // Memory responder and memory-side monitor.
  initial begin
    int cnt = -1;
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (rst_n && mem_req) begin
        if (cnt < 0) cnt = mem_lat;
        if (cnt == 0) begin
          cnt = -1;
          mem_ack = 1'b1;
          if (mem_we) begin
            mem_model[mem_addr[11:2]] = mem_wdata;
            if (exp_wa_q.size() == 0) check(1'b0, "R5 unexpected write", mem_addr, 32'h0);
            else begin
              logic [31:0] ea, ed;
              ea = exp_wa_q.pop_front();
              ed = exp_wd_q.pop_front();
              check(mem_addr == ea, "R5 write address", mem_addr, ea);
              check(mem_wdata == ed, "R5 write data", mem_wdata, ed);
            end
          end else begin
            mem_rdata = mem_model[mem_addr[11:2]];
            if (exp_fill_q.size() == 0) check(1'b0, "R4 unexpected read", mem_addr, 32'h0);
            else begin
              logic [31:0] ef;
              ef = exp_fill_q.pop_front();
              check(mem_addr == ef, "R4 fill address", mem_addr, ef);
            end
          end
        end else cnt--;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog R4: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] fd;
    logic        fr;
    for (int i = 0; i < MODEL_WORDS; i++) begin
      mem_model[i] = (i * 32'h0001_0203) ^ 32'hA500_0000;
      ref_mem[i]   = mem_model[i];
    end
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(cpu_ready == 1'b0, "R1 ready idle", cpu_ready, 32'd0);
    check(mem_req == 1'b0, "R1 memory idle", mem_req, 32'd0);

    // R1 / R4: cold miss, then R3 hits in the same line
    cpu_read(32'h100, 1'b1, "R1_R4 cold miss", fd, fr);
    cpu_read(32'h104, 1'b0, "R3 hit word1", fd, fr);
    cpu_read(32'h10C, 1'b0, "R3 hit word3", fd, fr);

    // R6 / R7: write hit, no stall, cached copy updated
    cpu_write(32'h104, 32'hDEAD_0104, 1'b0, "R7 write accept");
    cpu_read(32'h104, 1'b0, "R6 write hit readback", fd, fr);

    // R6 / R8: write miss to an aliasing line, slow memory
    mem_lat = 8;
    cpu_write(32'h208, 32'hBEEF_0208, 1'b0, "R7 write miss accept");
    cpu_read(32'h108, 1'b0, "R6 no allocate on write miss", fd, fr);
    cpu_read(32'h208, 1'b1, "R8 drain before fill", fd, fr);
    mem_lat = 2;

    // R10: speculative word in the first cycle of a miss
    cpu_read(32'h100, 1'b1, "R10 miss data", fd, fr);
    check(fr == 1'b0, "R10 ready low on miss", fr, 32'd0);
    check(fd == ref_mem[32'h200 >> 2], "R10 speculative word", fd, ref_mem[32'h200 >> 2]);

    // R2: index/tag split
    cpu_read(32'h110, 1'b1, "R2 index1 miss", fd, fr);
    cpu_read(32'h900, 1'b1, "R2 index0 new tag", fd, fr);
    cpu_read(32'h114, 1'b0, "R2 other index kept", fd, fr);
    cpu_read(32'h104, 1'b1, "R2 evicted line refetch", fd, fr);

    // R7 / R8: fill the buffer under long latency
    mem_lat = 20;
    cpu_write(32'h300, 32'h1111_0300, 1'b0, "R7 entry1");
    cpu_write(32'h310, 32'h2222_0310, 1'b0, "R7 entry2");
    cpu_write(32'h320, 32'h3333_0320, 1'b0, "R7 entry3");
    cpu_write(32'h330, 32'h4444_0330, 1'b0, "R7 entry4");
    cpu_write(32'h340, 32'h5555_0340, 1'b1, "R7 full stall");
    cpu_read(32'h340, 1'b1, "R8 read after buffered store", fd, fr);
    mem_lat = 1;

    // R6: write hit then read on the freshly filled line
    cpu_write(32'h344, 32'h6666_0344, 1'b0, "R7 write hit accept");
    cpu_read(32'h344, 1'b0, "R6 hit after write hit", fd, fr);
    cpu_read(32'h340, 1'b0, "R6 neighbour word kept", fd, fr);

    repeat (100) @(negedge clk);
    #1;
    check(mem_req == 1'b0, "R5 buffer drained", mem_req, 32'd0);
    check(exp_wa_q.size() == 0, "R5 all writes reached memory", exp_wa_q.size(), 32'd0);
    check(exp_fill_q.size() == 0, "R4 all fill reads issued", exp_fill_q.size(), 32'd0);
    check(exp_rd_q.size() == 0, "R3 all reads returned", exp_rd_q.size(), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule